// File: doc/BRIEF.md
# Queued Serial Port with Programmable Frame Format

This block is an asynchronous serial port seen by software as four 32-bit registers on a simple single-cycle register bus. Software queues bytes to send by writing the data register. The transmitter drains that queue one frame at a time. The receiver assembles incoming frames into a second queue, and software drains that queue by reading the same data register. Each read returns the oldest received byte with a valid flag in the same word, so software can poll one register without a separate status read.

The frame shape is set at run time from one configuration register. It holds the number of data bits (one to eight), the parity mode (none, even or odd) and the number of stop bits (one or two). A divider register sets the speed. The receiver oversamples the line at eight ticks per bit. It confirms a start bit at its centre before it accepts a frame, and it samples every later bit near its centre. A byte with a parity error or a bad stop bit is still queued, and the fault is kept in a sticky status flag. A byte that arrives when the receive queue is full is dropped, and this too is flagged.

Top module: `qser_uart`

## Requirements
- R1: After reset `ser_tx` is high, no bytes are queued in either direction, all error flags are clear, the divider reads 0 and the frame register reads 8 data bits, no parity and one stop bit (value 0x7).
- R2: The registers sit at byte offsets 0x0 (data), 0x4 (status), 0x8 (divider, bits 15:0) and 0xC (frame). Every read returns `bus_rdata` with `bus_rvalid` high in the cycle after the request.
- R3: A write to the data register queues bits 7:0 for sending. The frame on `ser_tx` is a low start bit, the data bits LSB first, an optional parity bit and then the high stop bits. Each bit lasts 8*(divider+1) clock cycles.
- R4: A read of the data register removes the oldest received byte and returns it in bits 7:0 with bit 16 set. When the receive queue is empty, bit 16 is 0 and nothing is removed.
- R5: Status bits 23:16 give the free transmit-queue slots and bits 31:24 give the number of received bytes waiting.
- R6: Frame bits 2:0 hold the data length minus one. A received byte shorter than eight bits is returned zero-extended.
- R7: Frame bits 9:8 select the parity: 0 none, 1 even, 2 odd (3 acts as none). With even parity the count of ones over the data and parity bits is even. With odd parity that count is odd.
- R8: Frame bit 16 selects the stop bits: 0 for one, 1 for two. With two stop bits the receiver checks both.
- R9: A received byte with a parity mismatch is queued and sets sticky status bit 0. A low stop bit queues the byte and sets sticky status bit 1. Writing a 1 to a status flag bit clears that flag.
- R10: A byte received while the receive queue is full is dropped and sets sticky status bit 2 (overflow).
- R11: A write to the data register while the transmit queue is full is ignored.
- R12: A low pulse on `ser_rx` that has ended by the centre of the start bit does not start a frame.
- R13: Both queues keep first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | High one cycle after a read request |
| ser_tx | output | 1 | Serial transmit line |
| ser_rx | input | 1 | Serial receive line |

## Verification
Register reads return data one clock after the request. The bench drives a request at a falling edge and samples at the next falling edge, after the capturing rising edge. The transmit line falls on the clock after a data write. The bench finds that falling edge and then samples every bit half a bit period into it, with the period taken from the divider. A received byte becomes visible a few cycles after the centre of its last stop bit, and the receive path adds up to one tick of start-detection jitter plus two synchroniser stages. For this reason every receive check waits until well past the end of the whole frame, and only then reads the status and data registers.

// File: rtl/qser_pkg.sv
package qser_pkg;

  typedef struct packed {
    logic       two_stop;
    logic [1:0] parity;
    logic [2:0] len_m1;
  } frame_t;

  localparam logic [3:0] OFS_DATA  = 4'h0;
  localparam logic [3:0] OFS_STAT  = 4'h4;
  localparam logic [3:0] OFS_DIV   = 4'h8;
  localparam logic [3:0] OFS_FRAME = 4'hC;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;

  function automatic logic par_on(input logic [1:0] p);
    return (p == PAR_EVEN) || (p == PAR_ODD);
  endfunction

  // parity bit over the first len_m1+1 data bits
  function automatic logic par_bit(input logic [7:0] d, input logic [2:0] len_m1,
                                   input logic odd);
    logic p;
    p = odd;
    for (int i = 0; i < 8; i++)
      if (i <= int'(len_m1)) p = p ^ d[i];
    return p;
  endfunction

endpackage

// File: rtl/qser_fifo.sv
module qser_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk)
    if (do_push) mem[wptr] <= din;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/qser_tx.sv
module qser_tx
  import qser_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  frame_t           cfg,
  input  logic [DIV_W-1:0] div,
  input  logic             q_empty,
  input  logic [7:0]       q_data,
  output logic             q_pop,
  output logic             ser_tx
);
  typedef enum logic [2:0] {T_IDLE, T_START, T_DATA, T_PAR, T_STOP} tst_e;

  tst_e             st;
  frame_t           fcfg;
  logic [7:0]       sh;
  logic             pbit;
  logic [2:0]       idx;
  logic             second;
  logic [DIV_W+2:0] ccnt;
  logic             bit_end;

  assign q_pop   = (st == T_IDLE) && !q_empty;
  assign bit_end = (ccnt == {div, 3'b111});

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= T_IDLE;
      ser_tx <= 1'b1;
      fcfg   <= '0;
      sh     <= '0;
      pbit   <= 1'b0;
      idx    <= '0;
      second <= 1'b0;
      ccnt   <= '0;
    end else if (st == T_IDLE) begin
      if (!q_empty) begin
        sh     <= q_data;
        fcfg   <= cfg;
        pbit   <= par_bit(q_data, cfg.len_m1, cfg.parity == PAR_ODD);
        ser_tx <= 1'b0;
        ccnt   <= '0;
        st     <= T_START;
      end
    end else if (!bit_end) begin
      ccnt <= ccnt + 1'b1;
    end else begin
      ccnt <= '0;
      case (st)
        T_START: begin
          ser_tx <= sh[0];
          sh     <= sh >> 1;
          idx    <= '0;
          st     <= T_DATA;
        end
        T_DATA: begin
          if (idx == fcfg.len_m1) begin
            if (par_on(fcfg.parity)) begin
              ser_tx <= pbit;
              st     <= T_PAR;
            end else begin
              ser_tx <= 1'b1;
              second <= 1'b0;
              st     <= T_STOP;
            end
          end else begin
            ser_tx <= sh[0];
            sh     <= sh >> 1;
            idx    <= idx + 1'b1;
          end
        end
        T_PAR: begin
          ser_tx <= 1'b1;
          second <= 1'b0;
          st     <= T_STOP;
        end
        T_STOP: begin
          if (fcfg.two_stop && !second) second <= 1'b1;
          else                          st     <= T_IDLE;
        end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qser_rx.sv
module qser_rx
  import qser_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_in,
  input  frame_t     cfg,
  output logic       push,
  output logic [7:0] data,
  output logic       perr,
  output logic       serr
);
  typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_PAR, R_STOP, R_WAITH} rst_e;

  rst_e       st;
  logic       s1, s2;
  logic [2:0] tcnt;
  logic [2:0] idx;
  logic       acc;
  logic       second;
  logic       perr_r, serr_r;
  logic       ctr_full;
  logic       bad_stop;

  assign ctr_full = (tcnt == 3'd7);
  assign bad_stop = serr_r || !s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
    end else begin
      s1 <= line_in;
      s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= R_IDLE;
      tcnt   <= '0;
      idx    <= '0;
      acc    <= 1'b0;
      second <= 1'b0;
      perr_r <= 1'b0;
      serr_r <= 1'b0;
      push   <= 1'b0;
      data   <= '0;
      perr   <= 1'b0;
      serr   <= 1'b0;
    end else begin
      push <= 1'b0;
      case (st)
        R_IDLE:
          if (tick && !s2) begin
            tcnt <= '0;
            st   <= R_START;
          end
        R_START:
          if (tick) begin
            if (tcnt == 3'd3) begin
              tcnt <= '0;
              if (!s2) begin
                idx    <= '0;
                acc    <= 1'b0;
                data   <= '0;
                perr_r <= 1'b0;
                serr_r <= 1'b0;
                second <= 1'b0;
                st     <= R_DATA;
              end else begin
                st <= R_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        R_DATA:
          if (tick) begin
            tcnt <= ctr_full ? '0 : tcnt + 1'b1;
            if (ctr_full) begin
              data[idx] <= s2;
              acc       <= acc ^ s2;
              if (idx == cfg.len_m1)
                st <= par_on(cfg.parity) ? R_PAR : R_STOP;
              else
                idx <= idx + 1'b1;
            end
          end
        R_PAR:
          if (tick) begin
            tcnt <= ctr_full ? '0 : tcnt + 1'b1;
            if (ctr_full) begin
              perr_r <= acc ^ s2 ^ (cfg.parity == PAR_ODD);
              st     <= R_STOP;
            end
          end
        R_STOP:
          if (tick) begin
            tcnt <= ctr_full ? '0 : tcnt + 1'b1;
            if (ctr_full) begin
              serr_r <= bad_stop;
              if (cfg.two_stop && !second) begin
                second <= 1'b1;
              end else begin
                push <= 1'b1;
                perr <= perr_r;
                serr <= bad_stop;
                st   <= bad_stop ? R_WAITH : R_IDLE;
              end
            end
          end
        R_WAITH:
          if (s2) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/qser_uart.sv
module qser_uart
  import qser_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int DIV_W    = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_rvalid,
  output logic        ser_tx,
  input  logic        ser_rx
);
  localparam int TCW = $clog2(TX_DEPTH+1);
  localparam int RCW = $clog2(RX_DEPTH+1);

  logic [DIV_W-1:0] div_q;
  frame_t           frame_q;
  logic [DIV_W-1:0] tk_cnt;
  logic             tick;
  logic             perr_f, serr_f, ovf_f;

  logic             wr_data, rd_data, wr_stat;
  logic             tx_pop, tx_empty, tx_full;
  logic [7:0]       tx_dout;
  logic [TCW-1:0]   tx_count;
  logic             rx_push, rx_empty, rx_full, rx_pop;
  logic [7:0]       rx_byte, rx_dout;
  logic [RCW-1:0]   rx_count;
  logic             rx_perr, rx_serr;
  logic [7:0]       tx_free8, rx_cnt8;

  assign wr_data  = bus_sel && bus_wr && (bus_addr == OFS_DATA);
  assign wr_stat  = bus_sel && bus_wr && (bus_addr == OFS_STAT);
  assign rd_data  = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
  assign rx_pop   = rd_data && !rx_empty;
  assign tick     = (tk_cnt >= div_q);
  assign tx_free8 = 8'(TX_DEPTH - int'(tx_count));
  assign rx_cnt8  = 8'(rx_count);

  always_ff @(posedge clk) begin
    if (rst) tk_cnt <= '0;
    else     tk_cnt <= tick ? '0 : tk_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      frame_q <= '{two_stop: 1'b0, parity: 2'd0, len_m1: 3'd7};
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == OFS_DIV) div_q <= bus_wdata[DIV_W-1:0];
      if (bus_addr == OFS_FRAME)
        frame_q <= '{two_stop: bus_wdata[16], parity: bus_wdata[9:8],
                     len_m1: bus_wdata[2:0]};
    end
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      perr_f <= 1'b0;
      serr_f <= 1'b0;
      ovf_f  <= 1'b0;
    end else begin
      if (rx_push && rx_perr)              perr_f <= 1'b1;
      else if (wr_stat && bus_wdata[0])    perr_f <= 1'b0;
      if (rx_push && rx_serr)              serr_f <= 1'b1;
      else if (wr_stat && bus_wdata[1])    serr_f <= 1'b0;
      if (rx_push && rx_full)              ovf_f  <= 1'b1;
      else if (wr_stat && bus_wdata[2])    ovf_f  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_sel && !bus_wr;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          OFS_DATA:  bus_rdata <= {15'd0, !rx_empty, 8'd0, rx_dout};
          OFS_STAT:  bus_rdata <= {rx_cnt8, tx_free8, 13'd0, ovf_f, serr_f, perr_f};
          OFS_DIV:   bus_rdata <= 32'(div_q);
          OFS_FRAME: bus_rdata <= {15'd0, frame_q.two_stop, 6'd0, frame_q.parity,
                                   5'd0, frame_q.len_m1};
          default:   bus_rdata <= '0;
        endcase
      end
    end
  end

  qser_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_data), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  qser_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst(rst), .cfg(frame_q), .div(div_q), .q_empty(tx_empty),
    .q_data(tx_dout), .q_pop(tx_pop), .ser_tx(ser_tx)
  );

  qser_rx u_rx (
    .clk(clk), .rst(rst), .tick(tick), .line_in(ser_rx), .cfg(frame_q),
    .push(rx_push), .data(rx_byte), .perr(rx_perr), .serr(rx_serr)
  );

  qser_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );
endmodule

// File: rtl/qser_uart_chk.sv
module qser_uart_chk #(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        bus_sel,
  input logic                        bus_wr,
  input logic [3:0]                  bus_addr,
  input logic [31:0]                 bus_rdata,
  input logic                        bus_rvalid,
  input logic [$clog2(TX_DEPTH+1)-1:0] tx_count,
  input logic [$clog2(RX_DEPTH+1)-1:0] rx_count,
  input logic                        tx_pop,
  input logic                        rx_push,
  input logic                        ovf_f
);
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr) |=> bus_rvalid); // R2

  AST_TXQ_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) == TX_DEPTH && !tx_pop) |=> (int'(tx_count) == TX_DEPTH)); // R11

  AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (rx_push && int'(rx_count) == RX_DEPTH) |=> ovf_f); // R10

  AST_VALID_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(bus_addr) == 4'h0 && bus_rdata[16]) |-> ($past(rx_count) != 0)); // R4

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (int'(tx_count) <= TX_DEPTH) && (int'(rx_count) <= RX_DEPTH)); // R5
endmodule

bind qser_uart qser_uart_chk #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_count(tx_count),
  .rx_count(rx_count), .tx_pop(tx_pop), .rx_push(rx_push), .ovf_f(ovf_f)
);

// File: tb/qser_uart_test.sv
module qser_uart_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        ser_tx;
  logic        loop = 1'b1;
  logic        drv = 1'b1;
  logic        ser_rx;
  int          checks = 0, errors = 0;
  logic [31:0] rd;

  assign ser_rx = loop ? ser_tx : drv;

  always #2 clk = ~clk;

  qser_uart uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .ser_tx(ser_tx), .ser_rx(ser_rx)
  );

  // {frame[31:0], byte sent, byte expected}
  localparam logic [47:0] VECS [0:6] = '{
    {32'h0000_0007, 8'h5A, 8'h5A},
    {32'h0000_0107, 8'hC3, 8'hC3},
    {32'h0001_0207, 8'h81, 8'h81},
    {32'h0000_0004, 8'hFF, 8'h1F},
    {32'h0001_0106, 8'hA5, 8'h25},
    {32'h0000_0200, 8'h03, 8'h01},
    {32'h0001_0005, 8'h2C, 8'h2C}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame on ser_rx, 8 clocks per bit (divider 0)
  task automatic send(input logic [7:0] d, input int nbits, input logic has_par,
                      input logic pbit, input logic st1, input logic two, input logic st2);
    @(negedge clk);
    drv = 1'b0; idle(8);
    for (int i = 0; i < nbits; i++) begin drv = d[i]; idle(8); end
    if (has_par) begin drv = pbit; idle(8); end
    drv = st1; idle(8);
    if (two) begin drv = st2; idle(8); end
    drv = 1'b1; idle(40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    check({31'd0, ser_tx}, 32'd1, "R1 ser_tx idle");
    rdreg(4'h4, rd); check(rd, 32'h0008_0000, "R1 R5 status after reset");
    rdreg(4'h0, rd); check(rd, 32'h0000_0000, "R4 empty read has no valid bit");
    rdreg(4'hC, rd); check(rd, 32'h0000_0007, "R1 R2 frame reset value");
    rdreg(4'h8, rd); check(rd, 32'h0000_0000, "R1 R2 divider reset value");

    // table walk, loopback, divider 0: R6 R7 R8
    for (int v = 0; v < 7; v++) begin
      wr(4'hC, VECS[v][47:16]);
      wr(4'h0, {24'd0, VECS[v][15:8]});
      idle(160);
      rdreg(4'h0, rd); check(rd, {15'd0, 1'b1, 8'd0, VECS[v][7:0]}, "R6 R7 R8 loopback byte");
      rdreg(4'h4, rd); check(rd, 32'h0008_0000, "R7 R8 no error flags");
    end

    // R3 bit timing with divider 1 (16 clocks a bit)
    wr(4'hC, 32'h0000_0007);
    wr(4'h8, 32'h0000_0001);
    rdreg(4'h8, rd); check(rd, 32'h0000_0001, "R2 divider readback");
    wr(4'h0, 32'h0000_00A5);
    while (ser_tx !== 1'b0) @(negedge clk);
    idle(8);
    for (int b = 0; b < 10; b++) begin
      logic [9:0] fr;
      fr = {1'b1, 8'hA5, 1'b0};
      check({31'd0, ser_tx}, {31'd0, fr[b]}, "R3 tx bit value");
      idle(16);
    end
    idle(40);
    rdreg(4'h0, rd); check(rd, 32'h0001_00A5, "R4 loopback at divider 1");
    wr(4'h8, 32'h0000_0000);

    // R11 R10 R13: fill the transmit queue, overflow the receive queue
    for (int i = 0; i < 10; i++) wr(4'h0, 32'h10 + i);
    rdreg(4'h4, rd); check(rd[23:16], 8'd0, "R11 R5 tx queue full");
    idle(1000);
    rdreg(4'h4, rd); check(rd, 32'h0808_0004, "R10 R5 rx full with overflow");
    for (int i = 0; i < 8; i++) begin
      rdreg(4'h0, rd); check(rd, 32'h0001_0010 + i, "R13 order of received bytes");
    end
    rdreg(4'h4, rd); check(rd, 32'h0008_0004, "R11 ignored write never sent");
    wr(4'h4, 32'h7);
    rdreg(4'h4, rd); check(rd, 32'h0008_0000, "R9 flags cleared by write");

    // bit-banged frames
    loop = 1'b0;
    wr(4'hC, 32'h0000_0107);
    send(8'h01, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    rdreg(4'h4, rd); check(rd, 32'h0108_0001, "R9 R7 even parity error flagged");
    rdreg(4'h0, rd); check(rd, 32'h0001_0001, "R9 byte with parity error queued");
    wr(4'h4, 32'h1);

    wr(4'hC, 32'h0000_0207);
    send(8'h01, 8, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    rdreg(4'h4, rd); check(rd, 32'h0108_0000, "R7 odd parity accepted");
    rdreg(4'h0, rd); check(rd, 32'h0001_0001, "R7 odd parity byte");

    wr(4'hC, 32'h0000_0007);
    send(8'h3C, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    rdreg(4'h4, rd); check(rd, 32'h0108_0002, "R9 stop error flagged");
    rdreg(4'h0, rd); check(rd, 32'h0001_003C, "R9 byte with stop error queued");
    wr(4'h4, 32'h2);

    wr(4'hC, 32'h0001_0007);
    send(8'h77, 8, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    rdreg(4'h4, rd); check(rd, 32'h0108_0002, "R8 second stop bit checked");
    rdreg(4'h0, rd); check(rd, 32'h0001_0077, "R8 two-stop byte");
    wr(4'h4, 32'h2);

    // R12 short glitch
    wr(4'hC, 32'h0000_0007);
    @(negedge clk); drv = 1'b0; idle(2); drv = 1'b1; idle(120);
    rdreg(4'h4, rd); check(rd, 32'h0008_0000, "R12 glitch rejected");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule